// File: doc/BRIEF.md
# Single-Cell Battery Protection Controller

This block is the decision logic of a one-cell battery protector. Digital comparator flags arrive from the analog front end: cell voltage against the overcharge, overcharge-release, over-discharge and over-discharge-release thresholds, and sense-pin voltage against two discharge over-current levels and one charge over-current level. Two presence flags tell it whether a charger and a load are attached. From these it drives the charge and discharge switch enables, the sense-pin pull-up and pull-down controls, and a shutdown flag.

A fault is accepted only after its flag has stayed true for a programmable number of clock ticks. Some releases are qualified the same way. If a flag drops before its count expires, the count starts again from zero. Each fault has its own recovery rule. Overcharge needs the charger gone and the cell below the release level. A short needs the load gone and the sense level back down. Deep discharge needs a charger and then a recovered cell. While the cell is overcharged, only the higher short-circuit threshold is watched on the sense pin. While the cell is over-discharged, charge over-current checking is off.

Top module: `cell_guard`

## Requirements
- R1: After reset the block is in normal mode: `chg_en`=1, `dchg_en`=1, `pull_up`=0, `pull_down`=0, `shutdown`=0.
- R2: In normal mode, `cell_ge_ov` held for T_OV consecutive rising edges leads to overcharge mode on the edge that completes the count. In overcharge mode `chg_en`=0 and `dchg_en`=1.
- R3: Overcharge mode returns to normal mode once `charger_on`=0 and `cell_lt_ovr`=1 have held together for T_OVR consecutive edges. While the charger stays attached, the block stays in overcharge.
- R4: In overcharge mode, `sense_ge_oc1` and `sense_ge_coc` have no effect. `sense_ge_oc2` held for T_SC edges enters the short state, where `chg_en`=0, `dchg_en`=0 and `pull_down`=1.
- R5: The short state returns to overcharge mode on the first edge where `load_on`=0 and `sense_ge_oc2`=0. While the load remains, the block stays in the short state.
- R6: In normal mode, `cell_lt_uv` held for T_UV edges enters shutdown: `dchg_en`=0, `chg_en`=1, `pull_up`=1, `shutdown`=1.
- R7: Shutdown is left only through `charger_on`=1, which moves the block on the next edge into a wake state with `shutdown`=0, `pull_up`=0, `dchg_en`=0 and `chg_en`=1. A recovered cell without a charger leaves it in shutdown.
- R8: The wake state returns to normal mode after `cell_gt_uvr` has held for T_UVR edges. `sense_ge_coc` has no effect in shutdown or in the wake state.
- R9: Every qualification count restarts from zero when its condition lapses before the count completes.
- R10: In normal mode, `sense_ge_oc1` held for T_DOC edges gives `dchg_en`=0 and `pull_down`=1. Normal mode resumes on the first edge with `load_on`=0 and `sense_ge_oc1`=0.
- R11: In normal mode, `sense_ge_coc` held for T_COC edges gives `chg_en`=0 with `dchg_en`=1. Normal mode resumes on the first edge with `charger_on`=0.
- R12: When several normal-mode faults complete their counts on the same edge, the priority is over-discharge, then overcharge, then discharge over-current, then charge over-current.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock for all timers |
| rst_n | input | 1 | Asynchronous active-low reset |
| cell_ge_ov | input | 1 | Cell at or above overcharge threshold |
| cell_lt_ovr | input | 1 | Cell below overcharge-release threshold |
| cell_lt_uv | input | 1 | Cell below over-discharge threshold |
| cell_gt_uvr | input | 1 | Cell above over-discharge-release threshold |
| sense_ge_oc1 | input | 1 | Sense pin at or above first discharge over-current level |
| sense_ge_oc2 | input | 1 | Sense pin at or above short-circuit level |
| sense_ge_coc | input | 1 | Sense pin beyond charge over-current level |
| charger_on | input | 1 | Charger attached |
| load_on | input | 1 | Load attached |
| chg_en | output | 1 | Charge switch enable |
| dchg_en | output | 1 | Discharge switch enable |
| pull_up | output | 1 | Sense-pin pull-up control |
| pull_down | output | 1 | Sense-pin pull-down control |
| shutdown | output | 1 | Internal bias shut off |

## Verification
The short state can be reached only through overcharge, so the stimulus first qualifies an overcharge. It then pulses the short-circuit flag one tick too short, to show the restart, before holding it long enough. It also asserts the lower over-current flags inside overcharge to show they are ignored. The priority of R12 needs two faults to complete on the same edge. The bench gets this by raising the flag with the longer delay earlier, offset by the difference between the two delays. A behavioural reference model with its own run-length counters is compared with every output on every clock.

// File: rtl/cell_guard.sv
module cell_guard #(
  parameter int T_OV  = 2000,
  parameter int T_OVR = 2000,
  parameter int T_SC  = 50,
  parameter int T_UV  = 1000,
  parameter int T_UVR = 1000,
  parameter int T_DOC = 200,
  parameter int T_COC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cell_ge_ov,
  input  logic cell_lt_ovr,
  input  logic cell_lt_uv,
  input  logic cell_gt_uvr,
  input  logic sense_ge_oc1,
  input  logic sense_ge_oc2,
  input  logic sense_ge_coc,
  input  logic charger_on,
  input  logic load_on,
  output logic chg_en,
  output logic dchg_en,
  output logic pull_up,
  output logic pull_down,
  output logic shutdown
);

  typedef enum logic [2:0] {S_NORM, S_OVCH, S_SHRT, S_SHUT, S_WAKE, S_DOC1, S_COC} st_t;

  localparam int NQ = 7;
  localparam int Q_UV = 0, Q_OV = 1, Q_DOC = 2, Q_COC = 3, Q_OVR = 4, Q_SC = 5, Q_UVR = 6;
  localparam int LIM [NQ] = '{T_UV, T_OV, T_DOC, T_COC, T_OVR, T_SC, T_UVR};
  localparam int M1 = (T_UV > T_OV) ? T_UV : T_OV;
  localparam int M2 = (T_DOC > T_COC) ? T_DOC : T_COC;
  localparam int M3 = (T_OVR > T_SC) ? T_OVR : T_SC;
  localparam int M4 = (M1 > M2) ? M1 : M2;
  localparam int M5 = (M3 > T_UVR) ? M3 : T_UVR;
  localparam int TMAX = (M4 > M5) ? M4 : M5;
  localparam int CW = $clog2(TMAX + 1);

  st_t st, nxt;
  logic [NQ-1:0] cond, fire;
  logic moving;

  assign cond[Q_UV]  = (st == S_NORM) && cell_lt_uv;
  assign cond[Q_OV]  = (st == S_NORM) && cell_ge_ov;
  assign cond[Q_DOC] = (st == S_NORM) && sense_ge_oc1;
  assign cond[Q_COC] = (st == S_NORM) && sense_ge_coc;
  assign cond[Q_OVR] = (st == S_OVCH) && !charger_on && cell_lt_ovr;
  assign cond[Q_SC]  = (st == S_OVCH) && sense_ge_oc2;
  assign cond[Q_UVR] = (st == S_WAKE) && cell_gt_uvr;

  assign moving = (nxt != st);

  for (genvar gi = 0; gi < NQ; gi++) begin : g_q
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else if (!cond[gi] || moving) cnt <= '0;
      else cnt <= cnt + 1'b1;
    end
    assign fire[gi] = cond[gi] && (cnt == CW'(LIM[gi] - 1));

    a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(LIM[gi] - 1));
    a_r9_cnt_restart: assert property (@(posedge clk) disable iff (!rst_n)
      !cond[gi] |=> cnt == '0);
  end

  always_comb begin
    nxt = st;
    unique case (st)
      S_NORM: begin
        if      (fire[Q_UV])  nxt = S_SHUT;
        else if (fire[Q_OV])  nxt = S_OVCH;
        else if (fire[Q_DOC]) nxt = S_DOC1;
        else if (fire[Q_COC]) nxt = S_COC;
      end
      S_OVCH: begin
        if      (fire[Q_SC])  nxt = S_SHRT;
        else if (fire[Q_OVR]) nxt = S_NORM;
      end
      S_SHRT: if (!load_on && !sense_ge_oc2) nxt = S_OVCH;
      S_SHUT: if (charger_on) nxt = S_WAKE;
      S_WAKE: if (fire[Q_UVR]) nxt = S_NORM;
      S_DOC1: if (!load_on && !sense_ge_oc1) nxt = S_NORM;
      S_COC:  if (!charger_on) nxt = S_NORM;
      default: nxt = S_NORM;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= S_NORM;
    else st <= nxt;
  end

  assign chg_en    = !(st == S_OVCH || st == S_SHRT || st == S_COC);
  assign dchg_en   = !(st == S_SHRT || st == S_SHUT || st == S_WAKE || st == S_DOC1);
  assign pull_down = (st == S_SHRT) || (st == S_DOC1);
  assign pull_up   = (st == S_SHUT);
  assign shutdown  = (st == S_SHUT);

  a_r2_chg_drop_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(chg_en) && $past(st) == S_NORM) |-> ($past(cell_ge_ov) || $past(sense_ge_coc)));
  a_r4_ovch_keeps_dchg: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_OVCH && !sense_ge_oc2) |=> dchg_en);
  a_r5_short_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SHRT && !load_on && !sense_ge_oc2) |=> (st == S_OVCH));
  a_r6_shut_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shutdown) |-> $past(cell_lt_uv));
  a_r7_shut_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown && !charger_on) |=> shutdown);
  a_r11_coc_release: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_COC && !charger_on) |=> chg_en);
  a_r10_doc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DOC1 && load_on) |=> (pull_down && !dchg_en));

endmodule

// File: tb/cell_guard_test.sv
module cell_guard_test;
  localparam int P_OV = 4, P_OVR = 3, P_SC = 2, P_UV = 5, P_UVR = 3, P_DOC = 3, P_COC = 2;

  logic clk = 0, rst_n = 0;
  logic cell_ge_ov = 0, cell_lt_ovr = 0, cell_lt_uv = 0, cell_gt_uvr = 0;
  logic sense_ge_oc1 = 0, sense_ge_oc2 = 0, sense_ge_coc = 0, charger_on = 0, load_on = 0;
  logic chg_en, dchg_en, pull_up, pull_down, shutdown;
  int n_tests = 0, n_fail = 0;

  always #2 clk = ~clk;

  cell_guard #(.T_OV(P_OV), .T_OVR(P_OVR), .T_SC(P_SC), .T_UV(P_UV), .T_UVR(P_UVR),
               .T_DOC(P_DOC), .T_COC(P_COC)) uut (
    .clk(clk), .rst_n(rst_n), .cell_ge_ov(cell_ge_ov), .cell_lt_ovr(cell_lt_ovr),
    .cell_lt_uv(cell_lt_uv), .cell_gt_uvr(cell_gt_uvr), .sense_ge_oc1(sense_ge_oc1),
    .sense_ge_oc2(sense_ge_oc2), .sense_ge_coc(sense_ge_coc), .charger_on(charger_on),
    .load_on(load_on), .chg_en(chg_en), .dchg_en(dchg_en), .pull_up(pull_up),
    .pull_down(pull_down), .shutdown(shutdown));

  // reference model: 0 normal, 1 overcharge, 2 short, 3 shutdown, 4 wake, 5 doc1, 6 coc
  int mode = 0;
  int r_uv = 0, r_ov = 0, r_doc = 0, r_coc = 0, r_ovr = 0, r_sc = 0, r_uvr = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode = 0; r_uv = 0; r_ov = 0; r_doc = 0; r_coc = 0; r_ovr = 0; r_sc = 0; r_uvr = 0;
    end else begin
      int nm;
      r_uv  = (mode == 0 && cell_lt_uv)   ? r_uv + 1  : 0;
      r_ov  = (mode == 0 && cell_ge_ov)   ? r_ov + 1  : 0;
      r_doc = (mode == 0 && sense_ge_oc1) ? r_doc + 1 : 0;
      r_coc = (mode == 0 && sense_ge_coc) ? r_coc + 1 : 0;
      r_ovr = (mode == 1 && !charger_on && cell_lt_ovr) ? r_ovr + 1 : 0;
      r_sc  = (mode == 1 && sense_ge_oc2) ? r_sc + 1  : 0;
      r_uvr = (mode == 4 && cell_gt_uvr)  ? r_uvr + 1 : 0;
      nm = mode;
      case (mode)
        0: if (r_uv >= P_UV) nm = 3; else if (r_ov >= P_OV) nm = 1;
           else if (r_doc >= P_DOC) nm = 5; else if (r_coc >= P_COC) nm = 6;
        1: if (r_sc >= P_SC) nm = 2; else if (r_ovr >= P_OVR) nm = 0;
        2: if (!load_on && !sense_ge_oc2) nm = 1;
        3: if (charger_on) nm = 4;
        4: if (r_uvr >= P_UVR) nm = 0;
        5: if (!load_on && !sense_ge_oc1) nm = 0;
        6: if (!charger_on) nm = 0;
        default: nm = 0;
      endcase
      if (nm != mode) begin
        r_uv = 0; r_ov = 0; r_doc = 0; r_coc = 0; r_ovr = 0; r_sc = 0; r_uvr = 0;
      end
      mode = nm;
    end
  end

  function automatic logic [4:0] exp_out(int m);
    // {chg_en, dchg_en, pull_up, pull_down, shutdown}
    case (m)
      0: return 5'b11000;
      1: return 5'b01000;
      2: return 5'b00010;
      3: return 5'b10101;
      4: return 5'b10000;
      5: return 5'b10010;
      default: return 5'b01000;
    endcase
  endfunction

  function automatic string tag_of(int m);
    case (m)
      0: return "R1"; 1: return "R2"; 2: return "R4"; 3: return "R6";
      4: return "R7"; 5: return "R10"; default: return "R11";
    endcase
  endfunction

  task automatic check(string tag, logic [4:0] act, logic [4:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: outputs %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // compare on every clock, away from the edge
  always @(negedge clk)
    if (rst_n) check(tag_of(mode), {chg_en, dchg_en, pull_up, pull_down, shutdown}, exp_out(mode));

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic named(string tag, logic [4:0] exp);
    check(tag, {chg_en, dchg_en, pull_up, pull_down, shutdown}, exp);
  endtask

  initial begin
    #20000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: expired, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    tick(2);
    rst_n = 1;
    tick(1);
    named("R1 reset", 5'b11000);

    // R9: short overcharge pulse restarts, then R2 full qualification
    cell_ge_ov = 1; tick(P_OV - 1); cell_ge_ov = 0; tick(1);
    named("R9 ov restart", 5'b11000);
    cell_ge_ov = 1; tick(P_OV - 1);
    named("R2 before count", 5'b11000);
    tick(1);
    named("R2 overcharge", 5'b01000);
    cell_ge_ov = 0;

    // R4: low over-current flags ignored in overcharge
    sense_ge_oc1 = 1; sense_ge_coc = 1; tick(6);
    named("R4 oc1/coc ignored", 5'b01000);
    sense_ge_oc1 = 0; sense_ge_coc = 0;
    sense_ge_oc2 = 1; tick(P_SC - 1); sense_ge_oc2 = 0; tick(1);
    named("R9 short restart", 5'b01000);
    load_on = 1; sense_ge_oc2 = 1; tick(P_SC);
    named("R4 short", 5'b00010);
    sense_ge_oc2 = 0; tick(3);
    named("R5 held by load", 5'b00010);
    load_on = 0; tick(1);
    named("R5 back to overcharge", 5'b01000);

    // R3: charger present blocks release
    charger_on = 1; cell_lt_ovr = 1; tick(6);
    named("R3 charger blocks", 5'b01000);
    charger_on = 0; tick(P_OVR);
    named("R3 release", 5'b11000);
    cell_lt_ovr = 0;

    // R10
    load_on = 1; sense_ge_oc1 = 1; tick(P_DOC);
    named("R10 doc1", 5'b10010);
    sense_ge_oc1 = 0; tick(2);
    named("R10 held by load", 5'b10010);
    load_on = 0; tick(1);
    named("R10 release", 5'b11000);

    // R11
    charger_on = 1; sense_ge_coc = 1; tick(P_COC);
    named("R11 coc", 5'b01000);
    sense_ge_coc = 0; tick(2);
    named("R11 held by charger", 5'b01000);
    charger_on = 0; tick(1);
    named("R11 release", 5'b11000);

    // R12: doc1 and coc complete on same edge -> doc1 wins
    sense_ge_oc1 = 1; tick(P_DOC - P_COC); sense_ge_coc = 1; tick(P_COC);
    named("R12 doc over coc", 5'b10010);
    sense_ge_oc1 = 0; sense_ge_coc = 0; tick(1);
    named("R12 doc1 released", 5'b11000);

    // R12: uv and ov complete on same edge -> uv wins
    cell_lt_uv = 1; tick(P_UV - P_OV); cell_ge_ov = 1; tick(P_OV);
    named("R12 uv over ov", 5'b10101);
    cell_ge_ov = 0;

    // R6..R8: shutdown, wake, recovery
    cell_lt_uv = 0; cell_gt_uvr = 1; sense_ge_coc = 1; tick(6);
    named("R7 no charger stays shut", 5'b10101);
    cell_gt_uvr = 0; charger_on = 1; tick(1);
    named("R7 wake", 5'b10000);
    tick(4);
    named("R8 coc ignored in wake", 5'b10000);
    sense_ge_coc = 0;
    cell_gt_uvr = 1; tick(P_UVR - 1); cell_gt_uvr = 0; tick(1);
    named("R9 uvr restart", 5'b10000);
    cell_gt_uvr = 1; tick(P_UVR);
    named("R8 recovered", 5'b11000);
    cell_gt_uvr = 0; charger_on = 0;

    // mid-run reset
    cell_ge_ov = 1; tick(P_OV);
    named("R2 again", 5'b01000);
    cell_ge_ov = 0; rst_n = 0; tick(1); rst_n = 1; tick(1);
    named("R1 after reset", 5'b11000);
    tick(3);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule